// File: doc/BRIEF.md
# Dual-Channel Compare Timer with Pulse Outputs

This block is a free-running up-counter with two compare channels. The counter advances by one on every clock where the count-clock enable and the run bit are both high. After each advance, each channel compares the counter's new value with its own compare register. A hit raises that channel's single-cycle match pulse and drives the channel's output pin.

Two output modes are offered. In PWM mode the counter wraps freely: an overflow starts the active phase of both pins, and each channel's own match ends it. In PPG mode channel 0 sets the period: the step after a channel-0 hit loads zero into the counter instead of incrementing it. That clearing step starts the active phase, and each channel's match ends it.

Each pin has an enable bit and an active-level bit. A disabled pin drives the inverse of its active level. Changes to the active level are accepted only while the pin is disabled.

Top module: `cmp_timer_top`

## Requirements
- R1: The counter advances by one only on clocks where run=1, tick=1 and clr_cnt=0. It holds its value otherwise. clr_cnt=1 forces it to zero and takes priority over a step.
- R2: Matches are evaluated only on a counting step, against the counter's new value. A compare write never causes a match pulse or a pin change. A write in the same cycle as a step takes effect only from the next step.
- R3: match_irq[k] is high for exactly one cycle, after the clock edge at which the counter took a value equal to compare register k. In PWM mode a compare value of 0 produces no match after a clear, and first matches when the counter wraps from all-ones to zero.
- R4: ovf_irq is high for exactly one cycle, after a step that moves the counter from all-ones to zero by incrementing. A PPG clear is not an overflow.
- R5: With mode_ppg=1, the step that follows a channel-0 match loads zero instead of incrementing, so the period is cmp0+1 steps. With cmp0=0, every clearing step matches again, so the counter stays at zero and channel 0 matches on every step.
- R6: In PWM mode (mode_ppg=0), an enabled pin becomes active on an overflow step and inactive on its channel's match step. When both happen on one step, the pin becomes inactive.
- R7: In PPG mode, an enabled pin becomes active on a clearing step and inactive on its channel's match step. When both happen on one step, the pin becomes inactive.
- R8: One cycle after out_en[k] is seen low, tmr_out[k] equals the inverse of act_lvl[k]. Disabling a pin discards its active phase, so re-enabling it starts at the inactive level.
- R9: Stopping the counter (run=0) keeps each pin's current level. After a restart the level is held until the next setting or clearing event.
- R10: The active level is captured on every clock where out_en[k]=0 and is frozen while out_en[k]=1. An act_lvl change that arrives in the same cycle out_en[k] rises is ignored.
- R11: After reset the counter and both compare registers are zero, all pulses are low and both pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-clock enable |
| run | input | 1 | Counter run bit |
| clr_cnt | input | 1 | Clear the counter to zero |
| mode_ppg | input | 1 | 0 = PWM, 1 = PPG |
| cmp_we | input | NUM_CH | Per-channel compare write strobe |
| cmp_wdata | input | CNT_W | Compare write data |
| out_en | input | NUM_CH | Per-channel pin enable |
| act_lvl | input | NUM_CH | Per-channel active level (1 = active high) |
| tmr_out | output | NUM_CH | Timer output pins |
| match_irq | output | NUM_CH | Per-channel match pulses |
| ovf_irq | output | 1 | Overflow pulse |

## Verification
The assertions assume that mode_ppg changes only while the counter is stopped or has just been cleared. Under that assumption, a pending PPG clear never crosses into PWM operation. The stimulus switches mode only after a clr_cnt pulse.

The assertions also assume a pin's enable and active level change only between steps. The directed scenarios change these inputs only on idle cycles, except for the deliberate case where the enable and the active level change together. All inputs are driven on the falling edge, so every rising edge samples settled values.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  typedef enum logic {
    MODE_PWM = 1'b0,
    MODE_PPG = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             sw_clr,
  input  tmr_mode_e        mode,
  input  logic             period_hit,
  output logic             step,
  output logic [CNT_W-1:0] nxt,
  output logic             wrap,
  output logic             restart_evt,
  output logic             ovf_pulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             ovf_q;
  logic             clr_now;

  assign step        = run & tick & ~sw_clr;
  assign clr_now     = (mode == MODE_PPG) & pend_q;
  assign nxt         = clr_now ? '0 : cnt_q + 1'b1;
  assign wrap        = step & ~clr_now & (cnt_q == CNT_MAX);
  assign restart_evt = step & clr_now;
  assign ovf_pulse   = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      ovf_q <= wrap;
      if (sw_clr) begin
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end else if (step) begin
        cnt_q  <= nxt;
        pend_q <= period_hit;
      end
    end
  end

  // R1: no step means the count holds
  p_hold_stopped_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && (!$past(run) || !$past(tick)) && !$past(sw_clr))
      |-> (cnt_q == $past(cnt_q)));

  // R5: a step taken with a pending PPG clear lands on zero
  p_ppg_clear_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(step) && $past(mode == MODE_PPG) && $past(pend_q))
      |-> (cnt_q == '0));

  // R4: overflow is a single-cycle pulse
  p_ovf_single_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> !ovf_q);
endmodule

// File: rtl/cmp_timer_match.sv
module cmp_timer_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             step,
  input  logic [CNT_W-1:0] nxt,
  output logic             hit,
  output logic             irq
);
  logic [CNT_W-1:0] cmp_q;
  logic             irq_q;

  assign hit = step & (nxt == cmp_q);
  assign irq = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit;
      if (wr_en) cmp_q <= wr_data;
    end
  end

  // R2: a compare write alone never yields a match pulse
  p_write_no_match_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !step) |=> !irq_q);
endmodule

// File: rtl/cmp_timer_outctl.sv
module cmp_timer_outctl
  import cmp_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      oe,
  input  logic      act_in,
  input  tmr_mode_e mode,
  input  logic      hit,
  input  logic      wrap,
  input  logic      restart_evt,
  output logic      pin
);
  logic lvl_q, lvl_d;
  logic act_q, act_new;
  logic pin_q, pin_d;
  logic set_evt;

  assign set_evt = (mode == MODE_PWM) ? wrap : restart_evt;

  always_comb begin
    if (!oe)          lvl_d = 1'b0;
    else if (hit)     lvl_d = 1'b0;
    else if (set_evt) lvl_d = 1'b1;
    else              lvl_d = lvl_q;
  end

  assign act_new = oe ? act_q : act_in;
  assign pin_d   = lvl_d ? act_new : ~act_new;
  assign pin     = pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      act_q <= 1'b1;
      pin_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      pin_q <= pin_d;
      if (!oe) act_q <= act_in;
    end
  end

  // R8: a disabled pin shows the inverse of the requested level
  p_disabled_inverse_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(oe)) |-> (pin_q == !$past(act_in)));

  // R10: the active level is frozen while enabled
  p_act_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(oe)) |-> (act_q == $past(act_q)));

  // R6, R7: a match leaves the pin at the inactive level
  p_match_inactive_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(hit)) |-> (pin_q == !act_q));
endmodule

// File: rtl/cmp_timer_top.sv
module cmp_timer_top
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              clr_cnt,
  input  logic              mode_ppg,
  input  logic [NUM_CH-1:0] cmp_we,
  input  logic [CNT_W-1:0]  cmp_wdata,
  input  logic [NUM_CH-1:0] out_en,
  input  logic [NUM_CH-1:0] act_lvl,
  output logic [NUM_CH-1:0] tmr_out,
  output logic [NUM_CH-1:0] match_irq,
  output logic              ovf_irq
);
  tmr_mode_e         mode;
  logic              step;
  logic [CNT_W-1:0]  nxt;
  logic              wrap;
  logic              restart_evt;
  logic              period_hit;
  logic [NUM_CH-1:0] hit_v;

  assign mode       = tmr_mode_e'(mode_ppg);
  assign period_hit = hit_v[0] & (mode == MODE_PPG);

  cmp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .run         (run),
    .sw_clr      (clr_cnt),
    .mode        (mode),
    .period_hit  (period_hit),
    .step        (step),
    .nxt         (nxt),
    .wrap        (wrap),
    .restart_evt (restart_evt),
    .ovf_pulse   (ovf_irq)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    cmp_timer_match #(.CNT_W(CNT_W)) u_match (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cmp_we[k]),
      .wr_data (cmp_wdata),
      .step    (step),
      .nxt     (nxt),
      .hit     (hit_v[k]),
      .irq     (match_irq[k])
    );

    cmp_timer_outctl u_out (
      .clk         (clk),
      .rst         (rst),
      .oe          (out_en[k]),
      .act_in      (act_lvl[k]),
      .mode        (mode),
      .hit         (hit_v[k]),
      .wrap        (wrap),
      .restart_evt (restart_evt),
      .pin         (tmr_out[k])
    );

    // R2: every match pulse follows a counting step
    p_irq_after_step_r2: assert property (@(posedge clk) disable iff (rst)
      match_irq[k] |-> $past(run && tick && !clr_cnt));
  end
endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_top_tb_top;
  localparam int CNT_W  = 16;
  localparam int NUM_CH = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick = 1'b0;
  logic              run = 1'b0;
  logic              clr_cnt = 1'b0;
  logic              mode_ppg = 1'b0;
  logic [NUM_CH-1:0] cmp_we = '0;
  logic [CNT_W-1:0]  cmp_wdata = '0;
  logic [NUM_CH-1:0] out_en = '0;
  logic [NUM_CH-1:0] act_lvl = 2'b11;
  logic [NUM_CH-1:0] tmr_out;
  logic [NUM_CH-1:0] match_irq;
  logic              ovf_irq;

  int n_chk = 0;
  int n_err = 0;
  int m0 = 0;
  int m1 = 0;
  int mo = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmp_timer_top #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .run       (run),
    .clr_cnt   (clr_cnt),
    .mode_ppg  (mode_ppg),
    .cmp_we    (cmp_we),
    .cmp_wdata (cmp_wdata),
    .out_en    (out_en),
    .act_lvl   (act_lvl),
    .tmr_out   (tmr_out),
    .match_irq (match_irq),
    .ovf_irq   (ovf_irq)
  );

  always @(negedge clk) begin
    if (!rst) begin
      m0 += int'(match_irq[0]);
      m1 += int'(match_irq[1]);
      mo += int'(ovf_irq);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic steps(input int n);
    @(negedge clk);
    run  = 1'b1;
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cmp(input logic [NUM_CH-1:0] mask, input logic [CNT_W-1:0] val);
    @(negedge clk);
    cmp_we    = mask;
    cmp_wdata = val;
    @(negedge clk);
    cmp_we = '0;
  endtask

  task automatic do_clr();
    @(negedge clk);
    clr_cnt = 1'b1;
    @(negedge clk);
    clr_cnt = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 pins", 32'(tmr_out), 0);
    chk("R11 match", 32'(match_irq), 0);
    chk("R11 ovf", 32'(ovf_irq), 0);
  endtask

  task automatic t_compare_write();
    int s;
    mode_ppg = 1'b0;
    do_clr();
    steps(3);
    s = m0;
    wr_cmp(2'b01, 16'd3);
    idle(2);
    chk("R2 write equal value no pulse", 32'(m0 - s), 0);
    chk("R2 no pin change", 32'(tmr_out), 0);
    steps(1);
    wr_cmp(2'b01, 16'd6);
    steps(1);
    chk("R1 count 5 no match", 32'(match_irq[0]), 0);
    steps(1);
    chk("R3 match at 6", 32'(match_irq[0]), 1);
    idle(1);
    chk("R3 pulse one cycle", 32'(match_irq[0]), 0);
    @(negedge clk);
    run  = 1'b0;
    tick = 1'b1;
    idle(10);
    tick = 1'b0;
    run  = 1'b1;
    idle(5);
    wr_cmp(2'b01, 16'd8);
    steps(1);
    chk("R1 held count, 7 no match", 32'(match_irq[0]), 0);
    steps(1);
    chk("R1 held count, 8 matches", 32'(match_irq[0]), 1);
    do_clr();
    wr_cmp(2'b01, 16'd1);
    steps(1);
    chk("R1 clear restarts at zero", 32'(match_irq[0]), 1);
    @(negedge clk);
    cmp_we    = 2'b01;
    cmp_wdata = 16'd2;
    run       = 1'b1;
    tick      = 1'b1;
    @(negedge clk);
    cmp_we = '0;
    tick   = 1'b0;
    chk("R2 write with step uses old value", 32'(match_irq[0]), 0);
  endtask

  task automatic t_ppg();
    mode_ppg = 1'b1;
    @(negedge clk);
    out_en = 2'b11;
    do_clr();
    wr_cmp(2'b01, 16'd3);
    wr_cmp(2'b10, 16'd1);
    steps(3);
    chk("R5 ch0 match at 3", 32'(match_irq[0]), 1);
    chk("R7 pin0 inactive", 32'(tmr_out[0]), 0);
    steps(1);
    chk("R7 clear makes pins active", 32'(tmr_out), 3);
    chk("R5 clear step no match", 32'(match_irq[0]), 0);
    steps(1);
    chk("R7 ch1 match", 32'(match_irq[1]), 1);
    chk("R7 pin1 inactive", 32'(tmr_out[1]), 0);
    steps(2);
    chk("R5 period of four", 32'(match_irq[0]), 1);
    steps(1);
    chk("R5 second clear pin0 active", 32'(tmr_out[0]), 1);
    @(negedge clk);
    run = 1'b0;
    idle(5);
    chk("R9 stopped keeps level", 32'(tmr_out[0]), 1);
    steps(2);
    chk("R9 restart keeps level", 32'(tmr_out[0]), 1);
    steps(1);
    chk("R9 next match ends level", 32'(tmr_out[0]), 0);
    wr_cmp(2'b11, 16'd0);
    steps(1);
    chk("R5 zero compare matches at clear", 32'(match_irq), 3);
    chk("R7 tie gives inactive", 32'(tmr_out), 0);
    steps(1);
    chk("R5 zero compare again", 32'(match_irq[0]), 1);
    steps(1);
    chk("R5 zero compare every step", 32'(match_irq[0]), 1);
  endtask

  task automatic t_disable();
    wr_cmp(2'b11, 16'd2);
    steps(1);
    chk("R7 clear without match active", 32'(tmr_out), 3);
    @(negedge clk);
    out_en = 2'b10;
    @(negedge clk);
    chk("R8 disabled is inverse of level 1", 32'(tmr_out[0]), 0);
    act_lvl = 2'b10;
    @(negedge clk);
    chk("R8 disabled is inverse of level 0", 32'(tmr_out[0]), 1);
    out_en  = 2'b11;
    act_lvl = 2'b11;
    @(negedge clk);
    chk("R10 level change with enable ignored", 32'(tmr_out[0]), 1);
    chk("R8 other pin unaffected", 32'(tmr_out[1]), 1);
    out_en = 2'b10;
    @(negedge clk);
    out_en = 2'b11;
    @(negedge clk);
    chk("R8 re-enable starts inactive", 32'(tmr_out[0]), 0);
  endtask

  task automatic t_pwm();
    int s0;
    int s1;
    int so;
    mode_ppg = 1'b0;
    do_clr();
    wr_cmp(2'b01, 16'd0);
    wr_cmp(2'b10, 16'd16);
    @(negedge clk);
    out_en = 2'b00;
    @(negedge clk);
    out_en = 2'b11;
    s0 = m0;
    so = mo;
    steps(65535);
    chk("R3 zero compare no early match", 32'(m0 - s0), 0);
    chk("R4 no early overflow", 32'(mo - so), 0);
    chk("R6 pins inactive before wrap", 32'(tmr_out), 0);
    steps(1);
    chk("R4 overflow pulse", 32'(ovf_irq), 1);
    chk("R3 zero compare matches at wrap", 32'(match_irq[0]), 1);
    chk("R6 tie gives inactive", 32'(tmr_out[0]), 0);
    chk("R6 overflow sets active", 32'(tmr_out[1]), 1);
    idle(1);
    chk("R4 overflow one cycle", 32'(ovf_irq), 0);
    steps(8);
    @(negedge clk);
    run = 1'b0;
    idle(4);
    chk("R9 PWM stop holds active", 32'(tmr_out[1]), 1);
    s1 = m1;
    steps(7);
    chk("R9 PWM restart holds active", 32'(tmr_out[1]), 1);
    chk("R6 no early ch1 match", 32'(m1 - s1), 0);
    steps(1);
    chk("R6 ch1 match", 32'(match_irq[1]), 1);
    chk("R6 match sets inactive", 32'(tmr_out[1]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_compare_write();
    t_ppg();
    t_disable();
    t_pwm();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1 run did not complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule